// File: doc/BRIEF.md
# Multi-port GPIO register controller

This block is a memory-mapped general-purpose pin controller. A simple register bus (byte address, write strobe, 32-bit write data, 32-bit read data) reaches four ports. Ports 0, 1 and 2 are bidirectional banks of 8, 24 and 13 pins. Port 3 packs three kinds of pin into shared 32-bit words: six bidirectional pins, 23 input-only pins and 24 output-only pins. It also has a plain 32-bit mux-select state word that drives an output bus.

Every output-level bit and every direction bit has its own write-one-to-set and write-one-to-clear address. Software can therefore change single pins without a read-modify-write sequence. Current values come back through state addresses. All pad inputs pass through a two-flop synchroniser before they appear in any input state word. Output levels and output enables go straight to the pad ports from the stored bits.

Top module: `gpio_quad_ctrl`

## Requirements
- R1: At reset every output level bit, direction bit and mux bit is 0, so all pad outputs, all output enables and `mux_sel` are 0, and every state address reads 0.
- R2: A write to a set address forces each bit written as 1 to 1 and leaves bits written as 0 unchanged (port 0 set at 0x44, port 1 set at 0x64, port 2 set at 0x20).
- R3: A write to a clear address forces each bit written as 1 to 0 and leaves bits written as 0 unchanged (port 0 clear at 0x48, port 1 clear at 0x68, port 2 clear at 0x24).
- R4: A direction bit of 1 enables the pin's output driver and 0 makes it an input. Port 0 direction set/clear/state is at 0x50/0x54/0x58, port 1 at 0x70/0x74/0x78, port 2 at 0x10/0x14/0x18.
- R5: On ports 0, 1 and 2, pin n is bit n of the level, direction and input words. Bits at or above the port width (8, 24, 13) are not stored and read 0. Level state is at 0x4C (port 0) and 0x6C (port 1).
- R6: The six port-3 bidirectional pins drive their levels from bits 25..30 of the port-3 level word (set 0x04, clear 0x08). Their output enables come from bits 25..30 of the port-2 direction word (0x10/0x14/0x18).
- R7: The port-3 input word at 0x00 holds the bidirectional inputs 0..4 on bits 10..14 and bidirectional input 5 on bit 24. The input-only pins 0..9 are on bits 0..9, pins 10..18 on bits 15..23 and pins 19..22 on bits 25..28. Bits 29..31 read 0.
- R8: The 24 output-only port-3 pins take bits 0..23 of the port-3 level word. The word reads back at 0x0C with bits 24 and 31 always 0, and writes to those two bits have no effect.
- R9: Set and clear addresses read 0, and unmapped addresses read 0.
- R10: Writes to state and input addresses (0x00, 0x0C, 0x18, 0x1C, 0x30, 0x40, 0x4C, 0x58, 0x60, 0x6C, 0x78) change nothing.
- R11: A pad input change applied between clock edges E0 and E1 is not visible after E1. It is visible in the input word after E2.
- R12: The mux-select word has set, clear and state addresses 0x28, 0x2C and 0x30 with the same set/clear rules, and drives `mux_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| p0_pad_in | input | 8 | Port 0 pad inputs |
| p0_pad_out | output | 8 | Port 0 output levels |
| p0_pad_oe | output | 8 | Port 0 output enables |
| p1_pad_in | input | 24 | Port 1 pad inputs |
| p1_pad_out | output | 24 | Port 1 output levels |
| p1_pad_oe | output | 24 | Port 1 output enables |
| p2_pad_in | input | 13 | Port 2 pad inputs |
| p2_pad_out | output | 13 | Port 2 output levels |
| p2_pad_oe | output | 13 | Port 2 output enables |
| p3_io_in | input | 6 | Port 3 bidirectional pad inputs |
| p3_io_out | output | 6 | Port 3 bidirectional output levels |
| p3_io_oe | output | 6 | Port 3 bidirectional output enables |
| p3_gpi | input | 23 | Port 3 input-only pads |
| p3_gpo | output | 24 | Port 3 output-only pads |
| mux_sel | output | 32 | Mux-select state word |

## Verification
The hardest case to reach is the port-3 cross-wiring. A single read of 0x00 must show bidirectional and input-only pads interleaved, and a single write to the port-2 direction address must move both port-2 enables and port-3 enables. The stimulus drives patterns where only one pin class is active: all input-only pads high with bidirectional pads low, then the reverse, then single pins on each segment boundary. This lets a misplaced bit in the packed word show up as a distinct wrong value. Direction writes that mix port-2 and port-3 bits are followed by checks of both pad enable groups and the shared direction state word.

// File: rtl/gqc_pkg.sv
package gqc_pkg;
  localparam int DW      = 32;
  localparam int IO3_N   = 6;
  localparam int IO3_LSB = 25;
  localparam int GPO_N   = 24;
  localparam int GPI_N   = 23;

  // register addresses
  localparam logic [7:0] A_P3_IN   = 8'h00;
  localparam logic [7:0] A_P3_OSET = 8'h04;
  localparam logic [7:0] A_P3_OCLR = 8'h08;
  localparam logic [7:0] A_P3_OST  = 8'h0C;
  localparam logic [7:0] A_P2_DSET = 8'h10;
  localparam logic [7:0] A_P2_DCLR = 8'h14;
  localparam logic [7:0] A_P2_DST  = 8'h18;
  localparam logic [7:0] A_P2_IN   = 8'h1C;
  localparam logic [7:0] A_P2_OSET = 8'h20;
  localparam logic [7:0] A_P2_OCLR = 8'h24;
  localparam logic [7:0] A_MX_SET  = 8'h28;
  localparam logic [7:0] A_MX_CLR  = 8'h2C;
  localparam logic [7:0] A_MX_ST   = 8'h30;
  localparam logic [7:0] A_P0_BASE = 8'h40;
  localparam logic [7:0] A_P1_BASE = 8'h60;

  // per-port offsets for ports 0 and 1
  localparam logic [7:0] OFF_IN   = 8'h00;
  localparam logic [7:0] OFF_OSET = 8'h04;
  localparam logic [7:0] OFF_OCLR = 8'h08;
  localparam logic [7:0] OFF_OST  = 8'h0C;
  localparam logic [7:0] OFF_DSET = 8'h10;
  localparam logic [7:0] OFF_DCLR = 8'h14;
  localparam logic [7:0] OFF_DST  = 8'h18;

  // pack the port-3 input word: irregular layout
  function automatic logic [DW-1:0] p3_in_word(input logic [IO3_N-1:0] bio,
                                               input logic [GPI_N-1:0] gpi);
    logic [DW-1:0] w;
    w        = '0;
    w[9:0]   = gpi[9:0];
    w[14:10] = bio[4:0];
    w[23:15] = gpi[18:10];
    w[24]    = bio[5];
    w[28:25] = gpi[22:19];
    return w;
  endfunction

  // pack the port-3 output-level word
  function automatic logic [DW-1:0] p3_out_word(input logic [GPO_N-1:0] gpo,
                                                input logic [IO3_N-1:0] bio);
    logic [DW-1:0] w;
    w = '0;
    w[GPO_N-1:0] = gpo;
    w[IO3_LSB +: IO3_N] = bio;
    return w;
  endfunction

  // next value of a set/clear register; clear has priority
  function automatic logic [DW-1:0] setclr_next(input logic [DW-1:0] cur,
                                                input logic [DW-1:0] d,
                                                input logic set_we,
                                                input logic clr_we);
    if (clr_we)      return cur & ~d;
    else if (set_we) return cur | d;
    else             return cur;
  endfunction
endpackage

// File: rtl/gqc_sync.sv
module gqc_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gqc_setclr_reg.sv
module gqc_setclr_reg
  import gqc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [DW-1:0] nxt;

  generate
    if (W == DW) begin : g_full
      assign nxt = setclr_next(q, wdata, set_we, clr_we);
    end else begin : g_part
      logic [DW-1:0] n_full;
      assign n_full = setclr_next({{(DW-W){1'b0}}, q}, {{(DW-W){1'b0}}, wdata},
                                  set_we, clr_we);
      assign nxt = n_full;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt[W-1:0];
  end
endmodule

// File: rtl/gqc_bidir_port.sv
module gqc_bidir_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         out_set,
  input  logic         out_clr,
  input  logic         dir_set,
  input  logic         dir_clr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] out_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] in_q
);
  gqc_setclr_reg #(.W(W)) u_lvl (
    .clk(clk), .rst_n(rst_n), .set_we(out_set), .clr_we(out_clr),
    .wdata(wdata), .q(out_q)
  );

  gqc_setclr_reg #(.W(W)) u_dir (
    .clk(clk), .rst_n(rst_n), .set_we(dir_set), .clr_we(dir_clr),
    .wdata(wdata), .q(dir_q)
  );

  gqc_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(in_q)
  );
endmodule

// File: rtl/gpio_quad_ctrl.sv
module gpio_quad_ctrl
  import gqc_pkg::*;
#(
  parameter int P0_W = 8,
  parameter int P1_W = 24,
  parameter int P2_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [P0_W-1:0]  p0_pad_in,
  output logic [P0_W-1:0]  p0_pad_out,
  output logic [P0_W-1:0]  p0_pad_oe,
  input  logic [P1_W-1:0]  p1_pad_in,
  output logic [P1_W-1:0]  p1_pad_out,
  output logic [P1_W-1:0]  p1_pad_oe,
  input  logic [P2_W-1:0]  p2_pad_in,
  output logic [P2_W-1:0]  p2_pad_out,
  output logic [P2_W-1:0]  p2_pad_oe,
  input  logic [IO3_N-1:0] p3_io_in,
  output logic [IO3_N-1:0] p3_io_out,
  output logic [IO3_N-1:0] p3_io_oe,
  input  logic [GPI_N-1:0] p3_gpi,
  output logic [GPO_N-1:0] p3_gpo,
  output logic [DW-1:0]    mux_sel
);
  // decoded write strobes, named for the checker
  logic wr_p0_oset, wr_p0_oclr, wr_p0_dset, wr_p0_dclr;
  logic wr_p1_oset, wr_p1_oclr, wr_p1_dset, wr_p1_dclr;
  logic wr_p2_oset, wr_p2_oclr, wr_p2_dset, wr_p2_dclr;
  logic wr_p3_oset, wr_p3_oclr, wr_mx_set, wr_mx_clr;

  assign wr_p0_oset = bus_wr && (bus_addr == A_P0_BASE + OFF_OSET);
  assign wr_p0_oclr = bus_wr && (bus_addr == A_P0_BASE + OFF_OCLR);
  assign wr_p0_dset = bus_wr && (bus_addr == A_P0_BASE + OFF_DSET);
  assign wr_p0_dclr = bus_wr && (bus_addr == A_P0_BASE + OFF_DCLR);
  assign wr_p1_oset = bus_wr && (bus_addr == A_P1_BASE + OFF_OSET);
  assign wr_p1_oclr = bus_wr && (bus_addr == A_P1_BASE + OFF_OCLR);
  assign wr_p1_dset = bus_wr && (bus_addr == A_P1_BASE + OFF_DSET);
  assign wr_p1_dclr = bus_wr && (bus_addr == A_P1_BASE + OFF_DCLR);
  assign wr_p2_oset = bus_wr && (bus_addr == A_P2_OSET);
  assign wr_p2_oclr = bus_wr && (bus_addr == A_P2_OCLR);
  assign wr_p2_dset = bus_wr && (bus_addr == A_P2_DSET);
  assign wr_p2_dclr = bus_wr && (bus_addr == A_P2_DCLR);
  assign wr_p3_oset = bus_wr && (bus_addr == A_P3_OSET);
  assign wr_p3_oclr = bus_wr && (bus_addr == A_P3_OCLR);
  assign wr_mx_set  = bus_wr && (bus_addr == A_MX_SET);
  assign wr_mx_clr  = bus_wr && (bus_addr == A_MX_CLR);

  // synchronised input state, named for the checker
  logic [P0_W-1:0]  p0_in_s;
  logic [P1_W-1:0]  p1_in_s;
  logic [P2_W-1:0]  p2_in_s;
  logic [IO3_N-1:0] p3_io_in_s;
  logic [GPI_N-1:0] p3_gpi_s;

  gqc_bidir_port #(.W(P0_W)) u_port0 (
    .clk(clk), .rst_n(rst_n),
    .out_set(wr_p0_oset), .out_clr(wr_p0_oclr),
    .dir_set(wr_p0_dset), .dir_clr(wr_p0_dclr),
    .wdata(bus_wdata[P0_W-1:0]), .pad_in(p0_pad_in),
    .out_q(p0_pad_out), .dir_q(p0_pad_oe), .in_q(p0_in_s)
  );

  gqc_bidir_port #(.W(P1_W)) u_port1 (
    .clk(clk), .rst_n(rst_n),
    .out_set(wr_p1_oset), .out_clr(wr_p1_oclr),
    .dir_set(wr_p1_dset), .dir_clr(wr_p1_dclr),
    .wdata(bus_wdata[P1_W-1:0]), .pad_in(p1_pad_in),
    .out_q(p1_pad_out), .dir_q(p1_pad_oe), .in_q(p1_in_s)
  );

  gqc_bidir_port #(.W(P2_W)) u_port2 (
    .clk(clk), .rst_n(rst_n),
    .out_set(wr_p2_oset), .out_clr(wr_p2_oclr),
    .dir_set(wr_p2_dset), .dir_clr(wr_p2_dclr),
    .wdata(bus_wdata[P2_W-1:0]), .pad_in(p2_pad_in),
    .out_q(p2_pad_out), .dir_q(p2_pad_oe), .in_q(p2_in_s)
  );

  // port 3: bidirectional levels, enables (in the port-2 direction word)
  gqc_setclr_reg #(.W(IO3_N)) u_p3_io_lvl (
    .clk(clk), .rst_n(rst_n), .set_we(wr_p3_oset), .clr_we(wr_p3_oclr),
    .wdata(bus_wdata[IO3_LSB +: IO3_N]), .q(p3_io_out)
  );

  gqc_setclr_reg #(.W(IO3_N)) u_p3_io_dir (
    .clk(clk), .rst_n(rst_n), .set_we(wr_p2_dset), .clr_we(wr_p2_dclr),
    .wdata(bus_wdata[IO3_LSB +: IO3_N]), .q(p3_io_oe)
  );

  gqc_setclr_reg #(.W(GPO_N)) u_p3_gpo (
    .clk(clk), .rst_n(rst_n), .set_we(wr_p3_oset), .clr_we(wr_p3_oclr),
    .wdata(bus_wdata[GPO_N-1:0]), .q(p3_gpo)
  );

  gqc_sync #(.W(IO3_N)) u_p3_io_sync (
    .clk(clk), .rst_n(rst_n), .d(p3_io_in), .q(p3_io_in_s)
  );

  gqc_sync #(.W(GPI_N)) u_p3_gpi_sync (
    .clk(clk), .rst_n(rst_n), .d(p3_gpi), .q(p3_gpi_s)
  );

  gqc_setclr_reg #(.W(DW)) u_mux (
    .clk(clk), .rst_n(rst_n), .set_we(wr_mx_set), .clr_we(wr_mx_clr),
    .wdata(bus_wdata), .q(mux_sel)
  );

  // read-back selection
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_P3_IN:               bus_rdata = p3_in_word(p3_io_in_s, p3_gpi_s);
      A_P3_OST:              bus_rdata = p3_out_word(p3_gpo, p3_io_out);
      A_P2_DST: begin
        bus_rdata[P2_W-1:0]          = p2_pad_oe;
        bus_rdata[IO3_LSB +: IO3_N]  = p3_io_oe;
      end
      A_P2_IN:               bus_rdata[P2_W-1:0] = p2_in_s;
      A_MX_ST:               bus_rdata = mux_sel;
      A_P0_BASE + OFF_IN:    bus_rdata[P0_W-1:0] = p0_in_s;
      A_P0_BASE + OFF_OST:   bus_rdata[P0_W-1:0] = p0_pad_out;
      A_P0_BASE + OFF_DST:   bus_rdata[P0_W-1:0] = p0_pad_oe;
      A_P1_BASE + OFF_IN:    bus_rdata[P1_W-1:0] = p1_in_s;
      A_P1_BASE + OFF_OST:   bus_rdata[P1_W-1:0] = p1_pad_out;
      A_P1_BASE + OFF_DST:   bus_rdata[P1_W-1:0] = p1_pad_oe;
      default:               bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gqc_checker.sv
module gqc_checker
  import gqc_pkg::*;
#(
  parameter int P0_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       bus_addr,
  input logic             bus_wr,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    bus_rdata,
  input logic [P0_W-1:0]  p0_pad_in,
  input logic [P0_W-1:0]  p0_pad_out,
  input logic [P0_W-1:0]  p0_pad_oe,
  input logic [P0_W-1:0]  p0_in_state,
  input logic [IO3_N-1:0] p3_io_out,
  input logic [IO3_N-1:0] p3_io_oe,
  input logic [GPO_N-1:0] p3_gpo
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_rst_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (p0_pad_oe == '0 && p3_io_oe == '0 && p0_pad_out == '0));

  assert_set_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_P0_BASE + OFF_OSET) |=>
      p0_pad_out == ($past(p0_pad_out) | $past(bus_wdata[P0_W-1:0])));

  assert_clr_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_P0_BASE + OFF_OCLR) |=>
      p0_pad_out == ($past(p0_pad_out) & ~$past(bus_wdata[P0_W-1:0])));

  assert_io_oe_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && (bus_addr == A_P2_DSET || bus_addr == A_P2_DCLR)) |=> $stable(p3_io_oe));

  assert_setclr_rd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_P3_OSET || bus_addr == A_P2_DCLR ||
     bus_addr == A_P0_BASE + OFF_OSET || bus_addr == A_MX_SET) |-> bus_rdata == '0);

  assert_ro_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_P3_OST) |=> ($stable(p3_gpo) && $stable(p3_io_out)));

  assert_sync_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> p0_in_state == $past(p0_pad_in, 2));
endmodule

bind gpio_quad_ctrl gqc_checker #(.P0_W(P0_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .p0_pad_in(p0_pad_in), .p0_pad_out(p0_pad_out), .p0_pad_oe(p0_pad_oe),
  .p0_in_state(p0_in_s), .p3_io_out(p3_io_out), .p3_io_oe(p3_io_oe),
  .p3_gpo(p3_gpo)
);

// File: tb/gpio_quad_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_quad_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  p0_pad_in = '0, p0_pad_out, p0_pad_oe;
  logic [23:0] p1_pad_in = '0, p1_pad_out, p1_pad_oe;
  logic [12:0] p2_pad_in = '0, p2_pad_out, p2_pad_oe;
  logic [5:0]  p3_io_in = '0, p3_io_out, p3_io_oe;
  logic [22:0] p3_gpi = '0;
  logic [23:0] p3_gpo;
  logic [31:0] mux_sel;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  gpio_quad_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .p0_pad_in(p0_pad_in), .p0_pad_out(p0_pad_out), .p0_pad_oe(p0_pad_oe),
    .p1_pad_in(p1_pad_in), .p1_pad_out(p1_pad_out), .p1_pad_oe(p1_pad_oe),
    .p2_pad_in(p2_pad_in), .p2_pad_out(p2_pad_out), .p2_pad_oe(p2_pad_oe),
    .p3_io_in(p3_io_in), .p3_io_out(p3_io_out), .p3_io_oe(p3_io_oe),
    .p3_gpi(p3_gpi), .p3_gpo(p3_gpo), .mux_sel(mux_sel)
  );

  // scoreboard of expected read results
  typedef struct {
    logic [7:0]  addr;
    logic [31:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t sb_q[$];
  logic rd_pending = 1'b0;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: presents the address and queues what the read must return
  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    rd_item_t it;
    it.addr = a; it.exp = exp; it.tag = tag;
    bus_addr = a;
    sb_q.push_back(it);
    rd_pending = 1'b1;
    wait (rd_pending == 1'b0);
  endtask

  // monitor: samples read data mid-cycle and compares
  always @(negedge clk) begin
    if (rd_pending && sb_q.size() > 0) begin
      rd_item_t it;
      it = sb_q.pop_front();
      check(bus_rdata, it.exp, it.tag);
      rd_pending = 1'b0;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1: reset state
    check(32'(p0_pad_oe), 0, "R1 p0 oe");
    check(32'(p3_io_oe), 0, "R1 p3 io oe");
    check(32'(p3_gpo), 0, "R1 p3 gpo");
    check(mux_sel, 0, "R1 mux_sel");
    rd(8'h4C, 0, "R1 p0 level state");
    rd(8'h18, 0, "R1 p2 dir state");
    rd(8'h0C, 0, "R1 p3 level state");

    // R2: set
    wr(8'h44, 32'hA5);
    check(32'(p0_pad_out), 32'hA5, "R2 p0 set pad");
    rd(8'h4C, 32'hA5, "R2 p0 set state");
    wr(8'h44, 32'h0A);
    rd(8'h4C, 32'hAF, "R2 zeros unchanged");

    // R3: clear
    wr(8'h48, 32'h0F);
    check(32'(p0_pad_out), 32'hA0, "R3 p0 clr pad");
    rd(8'h4C, 32'hA0, "R3 p0 clr state");
    wr(8'h20, 32'h1FFF);
    wr(8'h24, 32'h0F0F);
    check(32'(p2_pad_out), 32'h10F0, "R3 p2 clr pad");

    // R4: direction
    wr(8'h50, 32'h3C);
    check(32'(p0_pad_oe), 32'h3C, "R4 p0 dir set");
    wr(8'h54, 32'h0C);
    check(32'(p0_pad_oe), 32'h30, "R4 p0 dir clr");
    rd(8'h58, 32'h30, "R4 p0 dir state");
    wr(8'h70, 32'h800001);
    check(32'(p1_pad_oe), 32'h800001, "R4 p1 dir");

    // R5: widths and bit mapping
    wr(8'h64, 32'hFFFFFFFF);
    check(32'(p1_pad_out), 32'hFFFFFF, "R5 p1 width pad");
    rd(8'h6C, 32'h00FFFFFF, "R5 p1 width state");
    wr(8'h10, 32'h0000FFFF);
    check(32'(p2_pad_oe), 32'h1FFF, "R5 p2 dir width");
    rd(8'h18, 32'h00001FFF, "R5 p2 dir state width");
    wr(8'h44, 32'hFFFFFF00);
    rd(8'h4C, 32'hA0, "R5 p0 upper bits ignored");

    // R6: port-3 bidirectional levels and enables
    wr(8'h04, 32'h7E000000);
    check(32'(p3_io_out), 32'h3F, "R6 io levels");
    check(32'(p3_io_oe), 32'h00, "R6 io oe untouched by level write");
    wr(8'h10, 32'h2A000000);
    check(32'(p3_io_oe), 32'h15, "R6 io oe from p2 dir set");
    check(32'(p2_pad_oe), 32'h1FFF, "R6 p2 oe kept");
    rd(8'h18, 32'h2A001FFF, "R6 shared dir state");
    wr(8'h14, 32'h02000000);
    check(32'(p3_io_oe), 32'h14, "R6 io oe from p2 dir clr");

    // R8: output-only pins
    wr(8'h04, 32'h00FF00F0);
    check(32'(p3_gpo), 32'hFF00F0, "R8 gpo set");
    rd(8'h0C, 32'h7EFF00F0, "R8 level state");
    wr(8'h08, 32'h01000010);
    rd(8'h0C, 32'h7EFF00E0, "R8 gpo clr");
    wr(8'h04, 32'h81000000);
    rd(8'h0C, 32'h7EFF00E0, "R8 bits 24 and 31 ignored");

    // R7: port-3 input layout
    p3_gpi = 23'h7FFFFF; p3_io_in = 6'h00;
    idle(3);
    rd(8'h00, 32'h1EFF83FF, "R7 input-only pins");
    p3_gpi = 23'h0; p3_io_in = 6'h3F;
    idle(3);
    rd(8'h00, 32'h01007C00, "R7 bidir inputs");
    p3_io_in = 6'b100000;
    idle(3);
    rd(8'h00, 32'h01000000, "R7 bidir pin5 on bit 24");
    p3_gpi = 23'h080400; p3_io_in = 6'b000001;
    idle(3);
    rd(8'h00, 32'h02008400, "R7 segment boundaries");

    // R9: set/clear and unmapped addresses read zero
    rd(8'h44, 0, "R9 p0 set reads zero");
    rd(8'h04, 0, "R9 p3 set reads zero");
    rd(8'h14, 0, "R9 dir clr reads zero");
    rd(8'h3C, 0, "R9 unmapped 0x3C");
    rd(8'hFC, 0, "R9 unmapped 0xFC");

    // R10: writes to state addresses ignored
    wr(8'h4C, 32'h0);
    rd(8'h4C, 32'hA0, "R10 p0 state write ignored");
    wr(8'h0C, 32'h0);
    check(32'(p3_gpo), 32'hFF00E0, "R10 p3 state write gpo");
    wr(8'h00, 32'hFFFFFFFF);
    check(32'(p3_gpo), 32'hFF00E0, "R10 p3 input write gpo");
    wr(8'h58, 32'h0);
    check(32'(p0_pad_oe), 32'h30, "R10 p0 dir state write");
    wr(8'h18, 32'h0);
    check(32'(p3_io_oe), 32'h14, "R10 p2 dir state write");

    // R11: two-flop input latency
    @(posedge clk); #1;
    p0_pad_in = 8'h5A;
    @(posedge clk); #1;
    rd(8'h40, 32'h00, "R11 not visible after one edge");
    @(posedge clk); #1;
    rd(8'h40, 32'h5A, "R11 visible after two edges");
    p1_pad_in = 24'hABCDEF; p2_pad_in = 13'h1555;
    idle(3);
    rd(8'h60, 32'h00ABCDEF, "R11 p1 input state");
    rd(8'h1C, 32'h00001555, "R11 p2 input state");

    // R12: mux-select word
    wr(8'h28, 32'hF0F0F0F0);
    check(mux_sel, 32'hF0F0F0F0, "R12 mux set");
    wr(8'h2C, 32'h30000000);
    rd(8'h30, 32'hC0F0F0F0, "R12 mux state");
    check(mux_sel, 32'hC0F0F0F0, "R12 mux clr pad");

    idle(2);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule